// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Bank

This block controls one bank of up to 32 pins through a flat 32-bit register port. The port has a valid strobe, a write flag, a byte address and write data. Each pin is configured on its own. It can be a plain input, a driven output, or an interrupt source. An interrupt source watches its pin for an active level, or for a rising, falling or either-direction transition. Captured events collect in a status vector. A per-pin mask decides which events reach the single shared interrupt line.

Pin levels pass through a two-stage synchroniser before any use. An edge is found by comparing the synchronised level with its value one cycle earlier. Software acknowledges an edge event by writing a one to the acknowledge register. A level event stays pending for as long as the level stays active. The mask is changed through two write-only registers. One masks pins wherever a zero is written. The other unmasks pins wherever a one is written.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is an input, output data, status and all configuration registers read 0, every pin is masked, and `irq` is low.
- R2: With mode bit 0 (word at byte 0x00), the direction bit (0x04) drives `pin_oe` (1 = output) and `pin_out` always equals the output-data word (0x08).
- R3: A mode bit of 1 makes the pin an interrupt input. Its `pin_oe` bit is 0 whatever its direction bit holds.
- R4: Reading 0x0C returns the output-data bit for pins in general mode with direction 1. For every other pin it returns the pin level after two synchronising flops.
- R5: In level sensing (mode 1, sense bit at 0x24 = 0) the status bit (0x10) is 1 exactly while the synchronised level equals the active level: high when polarity (0x20) is 0, low when it is 1. Writing the acknowledge register does not clear it.
- R6: In edge sensing (sense bit 1), polarity 0 captures rising edges and polarity 1 captures falling edges. A both-edges bit (0x4C) of 1 captures every transition regardless of polarity. The status bit then holds until a 1 is written to that bit of the acknowledge word (0x14). A 0 there leaves it unchanged.
- R7: An edge detected in the same cycle as its acknowledge write leaves the status bit set.
- R8: Writing 0x18 masks each pin whose data bit is 0 and leaves pins with data bit 1 unchanged. Writing 0x1C unmasks each pin whose data bit is 1. Both words, and 0x14, read as 0.
- R9: `irq` is high exactly while some status bit is 1 for an unmasked pin. Masked pins still show their status at 0x10.
- R10: A pin in general mode never holds a status bit.
- R11: Writes to 0x0C and 0x10 change nothing, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output data to the pads |
| pin_oe | output | NUM_PINS | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The delicate overlap is an edge reaching the status logic in the same cycle that software writes the acknowledge bit for that pin. The bench changes a pin and then issues the acknowledge write after a swept number of idle cycles. One of those delays lands exactly on the detection cycle, where the bit must stay set. The delay one cycle later must leave the bit clear. A behavioural model built from vector operations follows every cycle, including a long random phase that mixes pin toggles, configuration writes and acknowledges. It judges `irq`, `pin_oe`, `pin_out` and every read.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_MODE   = 8'h00;
    localparam logic [ADDR_W-1:0] A_DIR    = 8'h04;
    localparam logic [ADDR_W-1:0] A_DOUT   = 8'h08;
    localparam logic [ADDR_W-1:0] A_DIN    = 8'h0C;
    localparam logic [ADDR_W-1:0] A_STAT   = 8'h10;
    localparam logic [ADDR_W-1:0] A_ACK    = 8'h14;
    localparam logic [ADDR_W-1:0] A_MASK   = 8'h18;
    localparam logic [ADDR_W-1:0] A_UNMASK = 8'h1C;
    localparam logic [ADDR_W-1:0] A_POL    = 8'h20;
    localparam logic [ADDR_W-1:0] A_SENSE  = 8'h24;
    localparam logic [ADDR_W-1:0] A_BOTH   = 8'h4C;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] lvl;
        logic [W-1:0] prev;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.meta = raw_i;
        r_d.lvl  = r_q.meta;
        r_d.prev = r_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign lvl_o  = r_q.lvl;
    assign prev_o = r_q.prev;

    // R4
    lvl_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prev_o == $past(lvl_o)));
endmodule

// File: rtl/gpio_bank_detect.sv
module gpio_bank_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] both_i,
    output logic [W-1:0] evt_o,
    output logic [W-1:0] act_o
);
    for (genvar g = 0; g < W; g++) begin : g_pin
        logic rise, fall;
        always_comb begin
            rise = lvl_i[g] & ~prev_i[g];
            fall = ~lvl_i[g] & prev_i[g];
            if (both_i[g])     evt_o[g] = rise | fall;
            else if (pol_i[g]) evt_o[g] = fall;
            else               evt_o[g] = rise;
            act_o[g] = lvl_i[g] ^ pol_i[g];
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int W = NUM_PINS;

    typedef struct packed {
        logic [W-1:0] mode;
        logic [W-1:0] dir;
        logic [W-1:0] dout;
        logic [W-1:0] pol;
        logic [W-1:0] sense;
        logic [W-1:0] both;
        logic [W-1:0] stat;
        logic [W-1:0] masked;
    } bank_t;

    bank_t st_d, st_q;

    logic [W-1:0] lvl, prev, evt, act;
    logic [W-1:0] wdat, ack_v, mask_wr_v, drives;
    logic         wr, rd;

    gpio_bank_sync #(.W(W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_in),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    gpio_bank_detect #(.W(W)) u_detect (
        .lvl_i  (lvl),
        .prev_i (prev),
        .pol_i  (st_q.pol),
        .both_i (st_q.both),
        .evt_o  (evt),
        .act_o  (act)
    );

    always_comb begin
        wr        = bus_valid & bus_write;
        rd        = bus_valid & ~bus_write;
        wdat      = bus_wdata[W-1:0];
        ack_v     = (wr && bus_addr == A_ACK) ? wdat : '0;
        mask_wr_v = (wr && bus_addr == A_MASK) ? ~wdat : '0;
        drives    = st_q.dir & ~st_q.mode;

        st_d = st_q;
        st_d.stat = (st_q.mode & ~st_q.sense & act)
                  | (st_q.mode & st_q.sense & (evt | (st_q.stat & ~ack_v)));
        if (wr) begin
            unique case (bus_addr)
                A_MODE:   st_d.mode   = wdat;
                A_DIR:    st_d.dir    = wdat;
                A_DOUT:   st_d.dout   = wdat;
                A_POL:    st_d.pol    = wdat;
                A_SENSE:  st_d.sense  = wdat;
                A_BOTH:   st_d.both   = wdat;
                A_MASK:   st_d.masked = st_q.masked | ~wdat;
                A_UNMASK: st_d.masked = st_q.masked & ~wdat;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.masked <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            unique case (bus_addr)
                A_MODE:  bus_rdata[W-1:0] = st_q.mode;
                A_DIR:   bus_rdata[W-1:0] = st_q.dir;
                A_DOUT:  bus_rdata[W-1:0] = st_q.dout;
                A_DIN:   bus_rdata[W-1:0] = (drives & st_q.dout) | (~drives & lvl);
                A_STAT:  bus_rdata[W-1:0] = st_q.stat;
                A_POL:   bus_rdata[W-1:0] = st_q.pol;
                A_SENSE: bus_rdata[W-1:0] = st_q.sense;
                A_BOTH:  bus_rdata[W-1:0] = st_q.both;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign pin_out = st_q.dout;
    assign pin_oe  = drives;
    assign irq     = |(st_q.stat & ~st_q.masked);

    // R10
    gen_mode_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.stat & ~$past(st_q.mode)) == '0));

    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_v & st_q.mode & st_q.sense & ~evt) != '0)
        |=> ((st_q.stat & $past(ack_v & st_q.mode & st_q.sense & ~evt)) == '0));

    // R7
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & st_q.mode & st_q.sense) != '0)
        |=> ((st_q.stat & $past(evt & st_q.mode & st_q.sense))
             == $past(evt & st_q.mode & st_q.sense)));

    // R5
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((act & st_q.mode & ~st_q.sense) != '0)
        |=> ((st_q.stat & $past(act & st_q.mode & ~st_q.sense))
             == $past(act & st_q.mode & ~st_q.sense)));

    // R8
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr_v != '0) |=> ((st_q.masked & $past(mask_wr_v)) == $past(mask_wr_v)));
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
    localparam int CLK_P = 10;
    localparam int NP    = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bv = 1'b0, bw = 1'b0;
    logic [7:0]      ba = '0;
    logic [31:0]     bd = '0;
    logic [31:0]     rdata;
    logic [NP-1:0]   pin_in = '0;
    logic [NP-1:0]   pin_out, pin_oe;
    logic            irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    gpio_bank #(.NUM_PINS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bv), .bus_write(bw),
        .bus_addr(ba), .bus_wdata(bd), .bus_rdata(rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // behavioural reference state
    logic [31:0] m_mode, m_dir, m_dout, m_pol, m_sense, m_both, m_stat, m_msk;
    logic [31:0] m_p1, m_p2, m_p3;

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [31:0] drv;
        drv = m_dir & ~m_mode;
        case (a)
            8'h00: return m_mode;
            8'h04: return m_dir;
            8'h08: return m_dout;
            8'h0C: return (drv & m_dout) | (~drv & m_p2);
            8'h10: return m_stat;
            8'h20: return m_pol;
            8'h24: return m_sense;
            8'h4C: return m_both;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [7:0] a);
        case (a)
            8'h0C: return "R4";
            8'h10: return "R5/R6";
            8'h14, 8'h18, 8'h1C: return "R8";
            8'h00, 8'h04, 8'h08: return "R2";
            8'h20, 8'h24, 8'h4C: return "R6";
            default: return "R11";
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_dir = 0; m_dout = 0; m_pol = 0; m_sense = 0;
            m_both = 0; m_stat = 0; m_msk = '1; m_p1 = 0; m_p2 = 0; m_p3 = 0;
        end else begin
            logic [31:0] rise, fall, ev, ack, nstat;
            rise = m_p2 & ~m_p3;
            fall = ~m_p2 & m_p3;
            ev   = (m_both & (rise | fall)) | (~m_both & ~m_pol & rise) | (~m_both & m_pol & fall);
            ack  = (bv && bw && ba == 8'h14) ? bd : 32'h0;
            nstat = 0;
            for (int i = 0; i < NP; i++) begin
                if (m_mode[i]) begin
                    if (!m_sense[i]) nstat[i] = (m_p2[i] != m_pol[i]);
                    else             nstat[i] = ev[i] || (m_stat[i] && !ack[i]);
                end
            end
            m_stat = nstat;
            m_p3 = m_p2; m_p2 = m_p1; m_p1 = pin_in;
            if (bv && bw) begin
                case (ba)
                    8'h00: m_mode  = bd;
                    8'h04: m_dir   = bd;
                    8'h08: m_dout  = bd;
                    8'h20: m_pol   = bd;
                    8'h24: m_sense = bd;
                    8'h4C: m_both  = bd;
                    8'h18: m_msk   = m_msk | ~bd;
                    8'h1C: m_msk   = m_msk & ~bd;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({31'b0, irq}, {31'b0, |(m_stat & ~m_msk)}, "R9 irq");
            chk(pin_oe, m_dir & ~m_mode, "R2/R3 pin_oe");
            chk(pin_out, m_dout, "R2 pin_out");
            if (bv && !bw) chk(rdata, exp_read(ba), read_tag(ba));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bv = 1; bw = 1; ba = a; bd = d;
        @(negedge clk); #1;
        bv = 0; bw = 0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] m,
                             input logic [31:0] e, input string tag);
        @(negedge clk); #1;
        bv = 1; bw = 0; ba = a;
        @(negedge clk);
        chk(rdata & m, e, tag);
        #1 bv = 0;
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk); #1 pin_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        #1 rst_n = 1;
        // R1 reset state
        expect_rd(8'h00, '1, 0, "R1 mode");
        expect_rd(8'h04, '1, 0, "R1 dir");
        expect_rd(8'h08, '1, 0, "R1 dout");
        expect_rd(8'h10, '1, 0, "R1 stat");
        chk({31'b0, irq}, 0, "R1 irq");
        chk(pin_oe, 0, "R1 oe");

        // R2 / R4 general output and readback
        wr(8'h08, 32'h0000_00A5);
        wr(8'h04, 32'h0000_000F);
        chk(pin_oe, 32'h0F, "R2 oe");
        chk(pin_out, 32'hA5, "R2 out");
        expect_rd(8'h0C, 32'hFF, 32'h05, "R4 out pins read dout");
        set_pins(32'hF0); idle(3);
        expect_rd(8'h0C, 32'hFF, 32'hF5, "R4 synced input");
        // R3 interrupt mode wins over direction
        wr(8'h00, 32'h1);
        chk(pin_oe, 32'h0E, "R3 mode priority");
        wr(8'h00, 0); wr(8'h04, 0);
        set_pins(0); idle(3);

        // interrupt configuration
        wr(8'h20, 32'h0A);
        wr(8'h24, 32'h1C);
        wr(8'h4C, 32'h10);
        wr(8'h00, 32'h1F);
        idle(2);
        expect_rd(8'h10, 32'h1F, 32'h02, "R5 level-low active");
        chk({31'b0, irq}, 0, "R8 masked");
        wr(8'h1C, 32'h02);
        chk({31'b0, irq}, 1, "R8 unmask");
        wr(8'h18, 32'hFFFF_FFFD);
        chk({31'b0, irq}, 0, "R8 mask by zero");
        wr(8'h18, 32'hFFFF_FFFF);
        chk({31'b0, irq}, 0, "R8 ones keep mask");
        expect_rd(8'h10, 32'h02, 32'h02, "R9 status visible when masked");
        expect_rd(8'h18, '1, 0, "R8 write-only");
        wr(8'h1C, 32'h1F);

        // level high pin0
        set_pins(32'h01); idle(3);
        expect_rd(8'h10, 32'h01, 32'h01, "R5 level-high set");
        wr(8'h14, 32'h01);
        expect_rd(8'h10, 32'h01, 32'h01, "R5 ack ignored while active");
        set_pins(32'h02); idle(3);
        expect_rd(8'h10, 32'h03, 32'h00, "R5 level released");

        // edges
        set_pins(32'h0E); idle(3);
        expect_rd(8'h10, 32'h0C, 32'h04, "R6 rising captured, falling pin idle");
        wr(8'h14, 32'h0);
        expect_rd(8'h10, 32'h04, 32'h04, "R6 ack zero no effect");
        wr(8'h14, 32'h04);
        expect_rd(8'h10, 32'h04, 32'h00, "R6 ack clears");
        set_pins(32'h06); idle(3);
        expect_rd(8'h10, 32'h08, 32'h08, "R6 falling captured");
        set_pins(32'h16); idle(3);
        expect_rd(8'h10, 32'h10, 32'h10, "R6 both rise");
        wr(8'h14, 32'h18);
        set_pins(32'h06); idle(3);
        expect_rd(8'h10, 32'h10, 32'h10, "R6 both fall");
        wr(8'h14, 32'h10);

        // R7 edge coinciding with ack
        set_pins(32'h16); idle(1); wr(8'h14, 32'h10);
        expect_rd(8'h10, 32'h10, 32'h10, "R7 edge beats ack");
        wr(8'h14, 32'h10);
        set_pins(32'h06); idle(2); wr(8'h14, 32'h10);
        expect_rd(8'h10, 32'h10, 32'h00, "R7 later ack clears");

        // R10 general pin toggling gives no status
        set_pins(32'h26); idle(3); set_pins(32'h06); idle(3);
        expect_rd(8'h10, 32'h20, 32'h00, "R10 general pin");

        // R11 read-only and unmapped
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        expect_rd(8'h10, 32'h20, 32'h00, "R11 status write ignored");
        expect_rd(8'h30, '1, 0, "R11 unmapped");

        // random phase, judged by the per-cycle model
        for (int it = 0; it < 3000; it++) begin
            logic [31:0] r;
            r = $urandom;
            @(negedge clk); #1;
            if (r[3:0] < 3) pin_in = $urandom;
            case (r[7:4])
                0: begin bv = 1; bw = 1; ba = 8'h00; bd = $urandom | 32'hFF; end
                1: begin bv = 1; bw = 1; ba = 8'h04; bd = $urandom; end
                2: begin bv = 1; bw = 1; ba = 8'h08; bd = $urandom; end
                3: begin bv = 1; bw = 1; ba = 8'h20; bd = $urandom; end
                4: begin bv = 1; bw = 1; ba = 8'h24; bd = $urandom; end
                5: begin bv = 1; bw = 1; ba = 8'h4C; bd = $urandom; end
                6, 7: begin bv = 1; bw = 1; ba = 8'h14; bd = $urandom; end
                8: begin bv = 1; bw = 1; ba = 8'h18; bd = $urandom | 32'hFFFF_0000; end
                9: begin bv = 1; bw = 1; ba = 8'h1C; bd = $urandom; end
                10, 11: begin bv = 1; bw = 0; ba = 8'h10; end
                12: begin bv = 1; bw = 0; ba = 8'h0C; end
                13: begin bv = 1; bw = 0; ba = {2'b0, r[13:8], 2'b00}; end
                default: bv = 0;
            endcase
        end
        @(negedge clk); #1 bv = 0;
        idle(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule